// File: doc/BRIEF.md
# Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic datapath of a small accumulator-style processor. An operation select chooses one of thirteen functions, which are applied to an accumulator operand and a memory operand together with the incoming carry and the decimal-mode flag. The result and the candidate flag values (negative, overflow, zero, carry) are produced combinationally. A write mask goes with them and marks which of the four flags the chosen operation is allowed to change.

A small status register holds the four flags. On a valid-operation strobe it merges the candidate values into its stored state, and only under the write mask. The surrounding decoder routes the operands. The shifts, rotates, increment and decrement act on the memory-side operand. Compare, bit test and the logic operations combine both operands. The operand width is a whole number of four-bit digits, so the packed-decimal path scales with it. Binary-coded decimal support can be removed at elaboration.

Top module: `alu_core`

## Requirements
- R1: Operation codes on `op_sel`: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right, 9 compare, 10 bit test, 11 increment, 12 decrement. Codes 13 to 15 give result 0 and write mask 0.
- R2: Flag vectors (`flags_next`, `flag_mask`, `flags_q`) are ordered bit 3 N, bit 2 V, bit 1 Z, bit 0 C. The write masks are: add and subtract 1111; and/or/xor, increment and decrement 1010; the four shifts and compare 1011; bit test 1110.
- R3: Binary add (`dec_mode`=0) gives result = (A + B + carry_in) modulo 256, and C is the carry out of bit 7.
- R4: Binary subtract gives result = A − B − (1 − carry_in) modulo 256. C=1 means no borrow occurred and C=0 means a borrow occurred.
- R5: After add or subtract, V is 1 exactly when the signed two's-complement result of the binary operation falls outside −128..+127. For example, 0x7F+0x01 gives V=1 and 0x81+0xFF with carry clear gives V=0. V is computed this way in decimal mode as well.
- R6: With `dec_mode`=1 and valid BCD operands, add gives the two-digit decimal sum modulo 100 in packed BCD, and C=1 when the sum reaches 100. Subtract gives the decimal difference modulo 100, and C=1 when the difference is not negative.
- R7: And, or and xor combine A with B bitwise.
- R8: Shift left puts 0 into bit 0 and old B bit 7 into C. Shift right puts 0 into bit 7 and old B bit 0 into C. Rotate left moves carry_in into bit 0 and bit 7 into C. Rotate right moves carry_in into bit 7 and bit 0 into C.
- R9: Compare leaves the result equal to A. It sets C=1 when A ≥ B unsigned and Z=1 when A = B, and N is bit 7 of A − B modulo 256.
- R10: Bit test leaves the result equal to A. It sets N to B bit 7, V to B bit 6, and Z to 1 when (A and B) is zero.
- R11: Increment and decrement give B ± 1 with wrap-around.
- R12: For every operation that writes them, except compare and bit test, N is bit 7 of the result and Z is 1 when the result is zero.
- R13: `flags_q` clears on a synchronous reset. It changes only on a clock edge with `strobe` high, and then only the bits set in `flag_mask` take the values of `flags_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation select |
| opa | input | 8 | Accumulator-side operand A |
| opb | input | 8 | Memory-side operand B |
| carry_in | input | 1 | Incoming carry |
| dec_mode | input | 1 | Decimal-mode flag for add and subtract |
| strobe | input | 1 | Valid-operation strobe for the flag register |
| result | output | 8 | Operation result |
| flags_next | output | 4 | Candidate N, V, Z, C values |
| flag_mask | output | 4 | Flags written by this operation |
| flags_q | output | 4 | Stored status flags |

## Verification
The bench builds the block with two decimal digits (an 8-bit datapath) and decimal support enabled. At this size every binary operand pair can be swept for add and subtract with both carry values, and every pair of valid BCD operands can be swept in decimal mode. All pairs are also covered for the two-operand logic, compare and bit-test functions. The unary shifts, rotates and counters are swept over every operand and carry. A short clocked sequence then exercises reset, strobed merges under the mask, holding with the strobe low, and an unused code.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_SHL = 4'd5,
      OP_SHR = 4'd6,
      OP_ROL = 4'd7,
      OP_ROR = 4'd8,
      OP_CMP = 4'd9,
      OP_BIT = 4'd10,
      OP_INC = 4'd11,
      OP_DEC = 4'd12
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } alu_flags_t;

   // Flags that each operation is permitted to write.
   function automatic alu_flags_t op_write_mask(input logic [3:0] op);
      alu_flags_t m;
      m = '0;
      case (op)
         OP_ADD, OP_SUB:                 m = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
         OP_AND, OP_OR, OP_XOR,
         OP_INC, OP_DEC:                 m = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
         OP_SHL, OP_SHR, OP_ROL, OP_ROR,
         OP_CMP:                         m = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         OP_BIT:                         m = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
         default:                        m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int  DIGITS = 2,
   parameter bit  BCD_EN = 1'b1,
   localparam int W      = 4 * DIGITS
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   input  logic         dec_en,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         vout
);

   // Binary path: subtraction adds the ones' complement.
   logic [W-1:0] b_eff;
   logic [W:0]   bin_full;

   always_comb begin
      b_eff    = sub ? ~b : b;
      bin_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
   end

   assign vout = (a[W-1] == b_eff[W-1]) && (bin_full[W-1] != a[W-1]);

   generate
      if (BCD_EN) begin : g_bcd
         // chain[i] is carry (add) or not-borrow (sub) into digit i
         logic [DIGITS:0] chain;
         logic [W-1:0]    dec_sum;

         assign chain[0] = cin;

         for (genvar d = 0; d < DIGITS; d++) begin : g_digit
            logic [3:0] ad, bd, fixed;
            logic [4:0] raw;
            logic       adj;

            assign ad = a[4*d +: 4];
            assign bd = b[4*d +: 4];

            always_comb begin
               if (sub) begin
                  raw   = {1'b0, ad} - {1'b0, bd} - {4'd0, ~chain[d]};
                  adj   = raw[4];
                  fixed = adj ? (raw[3:0] - 4'd6) : raw[3:0];
               end else begin
                  raw   = {1'b0, ad} + {1'b0, bd} + {4'd0, chain[d]};
                  adj   = (raw > 5'd9);
                  fixed = adj ? (raw[3:0] + 4'd6) : raw[3:0];
               end
            end

            assign dec_sum[4*d +: 4] = fixed;
            assign chain[d+1]        = sub ? ~adj : adj;
         end

         assign sum  = dec_en ? dec_sum        : bin_full[W-1:0];
         assign cout = dec_en ? chain[DIGITS]  : bin_full[W];
      end else begin : g_bin_only
         logic unused_dec;
         assign unused_dec = dec_en;
         assign sum  = bin_full[W-1:0];
         assign cout = bin_full[W];
      end
   endgenerate

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
   import alu_pkg::*;
#(
   parameter int  W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);

   always_comb begin
      res  = '0;
      cout = cin;
      case (op)
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         OP_SHL: begin res = {b[W-2:0], 1'b0}; cout = b[W-1]; end
         OP_SHR: begin res = {1'b0, b[W-1:1]}; cout = b[0];   end
         OP_ROL: begin res = {b[W-2:0], cin};  cout = b[W-1]; end
         OP_ROR: begin res = {cin, b[W-1:1]};  cout = b[0];   end
         OP_INC: res = b + {{(W-1){1'b0}}, 1'b1};
         OP_DEC: res = b - {{(W-1){1'b0}}, 1'b1};
         OP_CMP, OP_BIT: res = a;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       strobe,
   input  alu_flags_t next,
   input  alu_flags_t mask,
   output alu_flags_t q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (strobe)
         q <= (q & ~mask) | (next & mask);
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int  DIGITS = 2,
   parameter bit  BCD_EN = 1'b1,
   localparam int W      = 4 * DIGITS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [3:0]   op_sel,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         carry_in,
   input  logic         dec_mode,
   input  logic         strobe,
   output logic [W-1:0] result,
   output logic [3:0]   flags_next,
   output logic [3:0]   flag_mask,
   output logic [3:0]   flags_q
);

   generate
      if (DIGITS < 1 || DIGITS > 8) begin : g_bad_digits
         $error("alu_core: DIGITS must lie in 1..8");
      end
   endgenerate

   logic       is_add, is_sub, is_cmp, is_bit, is_arith;
   logic       as_sub, as_cin, as_dec;
   logic [W-1:0] as_sum, bo_res;
   logic       as_cout, as_v, bo_cout;
   alu_flags_t nxt, msk, q;

   always_comb begin
      is_add   = (op_sel == OP_ADD);
      is_sub   = (op_sel == OP_SUB);
      is_cmp   = (op_sel == OP_CMP);
      is_bit   = (op_sel == OP_BIT);
      is_arith = is_add | is_sub;
      // compare reuses the subtractor in binary with no borrow in
      as_sub   = is_sub | is_cmp;
      as_cin   = is_cmp ? 1'b1 : carry_in;
      as_dec   = dec_mode & is_arith;
   end

   alu_addsub #(.DIGITS(DIGITS), .BCD_EN(BCD_EN)) u_addsub (
      .a      (opa),
      .b      (opb),
      .cin    (as_cin),
      .sub    (as_sub),
      .dec_en (as_dec),
      .sum    (as_sum),
      .cout   (as_cout),
      .vout   (as_v)
   );

   alu_bitops #(.W(W)) u_bitops (
      .op   (op_sel),
      .a    (opa),
      .b    (opb),
      .cin  (carry_in),
      .res  (bo_res),
      .cout (bo_cout)
   );

   always_comb begin
      result = is_arith ? as_sum : bo_res;
      nxt.n  = result[W-1];
      nxt.z  = (result == '0);
      nxt.v  = 1'b0;
      nxt.c  = bo_cout;
      if (is_arith) begin
         nxt.v = as_v;
         nxt.c = as_cout;
      end else if (is_cmp) begin
         nxt.n = as_sum[W-1];
         nxt.z = (as_sum == '0);
         nxt.c = as_cout;
      end else if (is_bit) begin
         nxt.n = opb[W-1];
         nxt.v = opb[W-2];
         nxt.z = ((opa & opb) == '0);
      end
      msk = op_write_mask(op_sel);
   end

   alu_flag_reg u_flags (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .next   (nxt),
      .mask   (msk),
      .q      (q)
   );

   assign flags_next = nxt;
   assign flag_mask  = msk;
   assign flags_q    = q;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
   parameter int  W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic [3:0]   op_sel,
   input logic [W-1:0] opa,
   input logic [W-1:0] opb,
   input logic         strobe,
   input logic [W-1:0] result,
   input logic [3:0]   flags_next,
   input logic [3:0]   flag_mask,
   input logic [3:0]   flags_q
);

   // R13: reset clears the stored flags
   a_r13_reset_clears: assert property (@(posedge clk) rst |=> flags_q == 4'b0000);

   // R13: no strobe, no change
   a_r13_hold: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(flags_q));

   // R13: unmasked bits keep their value across a strobe
   a_r13_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
      strobe |=> ((flags_q & ~$past(flag_mask)) == ($past(flags_q) & ~$past(flag_mask))));

   // R13: masked bits take the candidate values
   a_r13_masked_loaded: assert property (@(posedge clk) disable iff (rst)
      strobe |=> ((flags_q & $past(flag_mask)) == ($past(flags_next) & $past(flag_mask))));

   // R10: bit test copies operand bits into N and V and keeps A as result
   a_r10_bit_copy: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 4'd10) |-> (flags_next[3] == opb[W-1] && flags_next[2] == opb[W-2] && result == opa));

   // R12: zero flag agrees with the result wherever it is derived from it
   a_r12_zero_tracks: assert property (@(posedge clk) disable iff (rst)
      (flag_mask[1] && op_sel != 4'd9 && op_sel != 4'd10) |-> (flags_next[1] == (result == '0)));

   // R2: V is never writable outside add, subtract and bit test
   a_r2_v_guard: assert property (@(posedge clk) disable iff (rst)
      (op_sel > 4'd1 && op_sel != 4'd10) |-> !flag_mask[2]);

endmodule

bind alu_core alu_core_chk #(.W(4 * DIGITS)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .op_sel     (op_sel),
   .opa        (opa),
   .opb        (opb),
   .strobe     (strobe),
   .result     (result),
   .flags_next (flags_next),
   .flag_mask  (flag_mask),
   .flags_q    (flags_q)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] op_sel;
   logic [7:0] opa, opb;
   logic       carry_in, dec_mode, strobe;
   logic [7:0] result;
   logic [3:0] flags_next, flag_mask, flags_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_core #(.DIGITS(2), .BCD_EN(1'b1)) dut (
      .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
      .carry_in(carry_in), .dec_mode(dec_mode), .strobe(strobe),
      .result(result), .flags_next(flags_next), .flag_mask(flag_mask),
      .flags_q(flags_q)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h c=%0d d=%0d got=%h exp=%h",
                  req, op_sel, opa, opb, carry_in, dec_mode, got, exp);
      end
   endtask

   function automatic int to_dec(input int v);
      return (v >> 4) * 10 + (v & 15);
   endfunction

   function automatic int to_bcd(input int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   // returns {result, flags (N V Z C), mask}
   function automatic logic [15:0] model(input int op, input int a, input int b,
                                         input int c, input int d);
      int r, s, bb;
      logic n, v, z, cy;
      logic [3:0] m;
      r = 0; n = 0; v = 0; z = 0; cy = 0; m = 4'b0000;
      case (op)
         0, 1: begin
            bb = (op == 1) ? 255 - b : b;
            s  = a + bb + c;
            v  = (((a ^ s) & (bb ^ s) & 128) != 0);
            if (d != 0) begin
               if (op == 0) begin
                  s = to_dec(a) + to_dec(b) + c;
                  cy = (s >= 100);
                  r = to_bcd(s % 100);
               end else begin
                  s = to_dec(a) - to_dec(b) - (1 - c);
                  cy = (s >= 0);
                  r = to_bcd((s + 100) % 100);
               end
            end else begin
               r = s & 255; cy = (s > 255);
            end
            m = 4'b1111;
         end
         2: begin r = a & b; m = 4'b1010; end
         3: begin r = a | b; m = 4'b1010; end
         4: begin r = a ^ b; m = 4'b1010; end
         5: begin r = (b << 1) & 255; cy = b[7]; m = 4'b1011; end
         6: begin r = b >> 1; cy = b[0]; m = 4'b1011; end
         7: begin r = ((b << 1) & 255) | c; cy = b[7]; m = 4'b1011; end
         8: begin r = (b >> 1) | (c << 7); cy = b[0]; m = 4'b1011; end
         11: begin r = (b + 1) & 255; m = 4'b1010; end
         12: begin r = (b + 255) & 255; m = 4'b1010; end
         default: ;
      endcase
      n = r[7]; z = (r == 0);
      if (op == 9) begin
         s = (a - b + 256) & 255;
         r = a; n = s[7]; z = (a == b); cy = (a >= b); m = 4'b1011;
      end
      if (op == 10) begin
         r = a; n = b[7]; v = b[6]; z = ((a & b) == 0); m = 4'b1110;
      end
      return {r[7:0], ({n, v, z, cy} & m), m};
   endfunction

   task automatic apply_and_check(input string req, input int op, input int a,
                                  input int b, input int c, input int d);
      op_sel = op[3:0]; opa = a[7:0]; opb = b[7:0]; carry_in = c[0]; dec_mode = d[0];
      #1;
      check(req, {result, flags_next & flag_mask, flag_mask}, model(op, a, b, c, d));
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; strobe = 1'b0; op_sel = 4'd0; opa = '0; opb = '0;
      carry_in = 1'b0; dec_mode = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R13 reset", {12'h0, flags_q}, 16'h0000);
      rst = 1'b0;

      // R3 R4 R5: binary add and subtract, every pair and carry
      for (int op = 0; op < 2; op++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               for (int c = 0; c < 2; c++)
                  apply_and_check(op == 0 ? "R3 R5 add" : "R4 R5 sub", op, a, b, c, 0);

      // R5 documented overflow examples
      apply_and_check("R5 7F+01", 0, 8'h7F, 8'h01, 0, 0);
      check("R5 V set", {15'd0, flags_next[2]}, 16'd1);
      apply_and_check("R5 81+FF", 0, 8'h81, 8'hFF, 0, 0);
      check("R5 V clear", {15'd0, flags_next[2]}, 16'd0);

      // R6: decimal add and subtract over all valid BCD pairs
      for (int op = 0; op < 2; op++)
         for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b++)
               for (int c = 0; c < 2; c++)
                  apply_and_check("R6 decimal", op, to_bcd(a), to_bcd(b), c, 1);

      // R7 R9 R10 R12: two-operand functions, decimal flag toggled (no effect)
      for (int op = 2; op < 11; op++) begin
         if (op >= 5 && op <= 8) continue;
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               apply_and_check(op == 9 ? "R9 compare" : (op == 10 ? "R10 bit" : "R7 R12 logic"),
                               op, a, b, b & 1, a & 1);
      end

      // R8 R11 R12: unary functions over every operand and carry
      for (int op = 5; op < 13; op++) begin
         if (op == 9 || op == 10) continue;
         for (int b = 0; b < 256; b++)
            for (int c = 0; c < 2; c++)
               apply_and_check(op > 10 ? "R11 inc/dec" : "R8 shift", op, 8'h5A, b, c, c);
      end

      // R1 R2: unused codes
      for (int op = 13; op < 16; op++)
         apply_and_check("R1 unused", op, 8'hA5, 8'h3C, 1, 0);

      // R13: clocked merges
      @(negedge clk);
      op_sel = 4'd0; opa = 8'h7F; opb = 8'h01; carry_in = 0; dec_mode = 0; strobe = 1;
      @(negedge clk); strobe = 0;
      check("R13 full write", {12'h0, flags_q}, 16'b1100);
      op_sel = 4'd0; opa = 8'h00; opb = 8'h00;
      @(negedge clk); @(negedge clk);
      check("R13 hold", {12'h0, flags_q}, 16'b1100);
      op_sel = 4'd11; opb = 8'hFF; strobe = 1;
      @(negedge clk); strobe = 0;
      check("R13 R2 V kept on inc", {12'h0, flags_q}, 16'b0110);
      op_sel = 4'd5; opb = 8'h80; carry_in = 0; strobe = 1;
      @(negedge clk); strobe = 0;
      check("R13 shift write", {12'h0, flags_q}, 16'b0111);
      op_sel = 4'd14; strobe = 1;
      @(negedge clk); strobe = 0;
      check("R13 R1 unused no write", {12'h0, flags_q}, 16'b0111);
      rst = 1;
      @(negedge clk); rst = 0;
      check("R13 reset again", {12'h0, flags_q}, 16'h0000);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule